// File: doc/BRIEF.md
# ADC channel scan sequencer

This block is the digital control for an eight-input analog-to-digital converter. A register-style control word picks the channels, sets the converter clock divisor, enables repeated scanning, carries a start code and gates power. The block divides the bus clock into converter clock ticks. It runs one conversion on request, or keeps cycling through the selected channels. Each conversion lasts a fixed number of converter ticks. On the final tick the block captures the sample present on its sample input.

Every finished conversion writes that channel's result register and raises its DONE flag. If the previous result was still unread, it also raises the channel's OVERRUN flag. A one-cycle read strobe per channel marks a result as consumed. A single interrupt output is high whenever any DONE flag is set.

Top module: `adc_scan_seq`

## Requirements
- R1: A select field of all zeros behaves exactly as if only bit 0 (channel 0) were set; select bit n names channel n.
- R2: A conversion keeps `busy` high for CONV_CLKS × (divisor + 1) bus cycles, where one converter tick is divisor + 1 bus cycles (CONV_CLKS defaults to 65).
- R3: A single conversion starts on the edge where the start field reads 3'b001 after holding another value the edge before. It starts only while idle, powered and not in burst, and it uses the lowest selected channel. Any other start code starts nothing.
- R4: While burst is 1, a start-code transition to 3'b001 starts no conversion.
- R5: In burst mode, conversions run back to back with one idle bus cycle between them. The first uses the lowest set select bit, and each later one uses the next higher set bit, wrapping to the lowest.
- R6: While burst is 1 and the start field is nonzero, no conversion begins.
- R7: Clearing burst during a conversion lets that conversion finish and write its result, and no further conversion begins.
- R8: While the power bit is 0, no conversion runs. Dropping it mid-conversion ends `busy` on the next edge without writing a result.
- R9: At the end of a conversion, the sample input value present on the final tick goes into that channel's result (bits [ch*DW +: DW] of `result_flat`), that channel's DONE flag is set, and `conv_ch` shows the channel.
- R10: A read strobe bit n clears DONE and OVERRUN of channel n on the next edge. If a result is written to the same channel on the same edge, the write wins: DONE is 1 and OVERRUN is 0.
- R11: A result written to a channel whose DONE is still 1 (and not being read) sets that channel's OVERRUN. OVERRUN is never 1 while DONE is 0.
- R12: `irq` is 1 exactly when at least one DONE flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_sel | input | NCH | Channel select bits |
| ctl_div | input | DIVW | Converter clock divisor minus one |
| ctl_burst | input | 1 | Repeated scan enable |
| ctl_start | input | 3 | Start code; 3'b001 requests one conversion |
| ctl_pwr | input | 1 | 1 = converter operational, 0 = powered down |
| sample_in | input | DW | Digitized value from the analog front end |
| rd_strobe | input | NCH | One-cycle per-channel result-consumed pulses |
| result_flat | output | NCH*DW | Per-channel results, channel n at [n*DW +: DW] |
| done_flags | output | NCH | Per-channel result-ready flags |
| ovr_flags | output | NCH | Per-channel overwritten-unread flags |
| irq | output | 1 | Any DONE flag set |
| busy | output | 1 | Conversion in progress |
| conv_ch | output | $clog2(NCH) | Channel of the current or last conversion |

## Verification
A start code is seen on the first rising edge after it is driven, and `busy` rises on that same edge. `busy` then stays high for exactly CONV_CLKS × (divisor + 1) edges. The result, DONE and OVERRUN appear on the edge where `busy` falls, and in burst the next conversion begins one edge later. Read strobes and power-down act on the next edge. The bench drives inputs on falling edges and samples on falling edges. It counts falling edges from the accepting edge to the fall of `busy` and compares that count with the formula. Flags and results are compared only after the edge that should have produced them.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
   localparam logic [2:0] START_NONE   = 3'b000;
   localparam logic [2:0] START_SINGLE = 3'b001;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
   parameter int DIVW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [DIVW-1:0] div,
   output logic            tick
);
   logic [DIVW-1:0] cnt;

   assign tick = run && (cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run)   cnt <= '0;
      else if (tick)   cnt <= '0;
      else             cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
   parameter int NCH = 8,
   localparam int CHW = $clog2(NCH)
) (
   input  logic [NCH-1:0] sel,
   input  logic [CHW-1:0] last,
   input  logic           restart,
   output logic [CHW-1:0] ch
);
   logic [CHW-1:0] lowest;
   logic [CHW-1:0] above;
   logic           has_above;

   always_comb begin
      lowest    = '0;
      above     = '0;
      has_above = 1'b0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (sel[i]) begin
            lowest = CHW'(i);
            if (i > int'(last)) begin
               above     = CHW'(i);
               has_above = 1'b1;
            end
         end
      end
      ch = (restart || !has_above) ? lowest : above;
   end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
   parameter int NCH = 8,
   parameter int DW  = 12,
   localparam int CHW = $clog2(NCH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [CHW-1:0]  wr_ch,
   input  logic [DW-1:0]   wr_data,
   input  logic [NCH-1:0]  rd_strobe,
   output logic [NCH*DW-1:0] result_flat,
   output logic [NCH-1:0]  done_flags,
   output logic [NCH-1:0]  ovr_flags
);
   for (genvar g = 0; g < NCH; g++) begin : g_chan
      logic hit;
      assign hit = wr_en && (wr_ch == CHW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            result_flat[g*DW +: DW] <= '0;
            done_flags[g]           <= 1'b0;
            ovr_flags[g]            <= 1'b0;
         end else if (hit) begin
            result_flat[g*DW +: DW] <= wr_data;
            done_flags[g]           <= 1'b1;
            ovr_flags[g]            <= (done_flags[g] || ovr_flags[g]) && !rd_strobe[g];
         end else if (rd_strobe[g]) begin
            done_flags[g] <= 1'b0;
            ovr_flags[g]  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adc_scan_pkg::*;
#(
   parameter int NCH       = 8,
   parameter int DW        = 12,
   parameter int DIVW      = 8,
   parameter int CONV_CLKS = 65,
   localparam int CHW  = $clog2(NCH),
   localparam int CNTW = $clog2(CONV_CLKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    ctl_sel,
   input  logic [DIVW-1:0]   ctl_div,
   input  logic              ctl_burst,
   input  logic [2:0]        ctl_start,
   input  logic              ctl_pwr,
   input  logic [DW-1:0]     sample_in,
   input  logic [NCH-1:0]    rd_strobe,
   output logic [NCH*DW-1:0] result_flat,
   output logic [NCH-1:0]    done_flags,
   output logic [NCH-1:0]    ovr_flags,
   output logic              irq,
   output logic              busy,
   output logic [CHW-1:0]    conv_ch
);
   if (NCH < 2 || (1 << CHW) != NCH) begin : g_bad_nch
      $error("adc_scan_seq: NCH must be a power of two of at least 2");
   end
   if (CONV_CLKS < 2) begin : g_bad_conv
      $error("adc_scan_seq: CONV_CLKS must be at least 2");
   end
   if (DW < 1 || DIVW < 1) begin : g_bad_width
      $error("adc_scan_seq: DW and DIVW must be positive");
   end

   logic [NCH-1:0]  sel_eff;
   logic [2:0]      start_q;
   logic            scan_live;
   logic [CNTW-1:0] tick_cnt;
   logic            tick;
   logic            sw_go;
   logic            bu_go;
   logic            last_tick;
   logic            wr_en;
   logic [CHW-1:0]  ch_next;

   assign sel_eff   = (ctl_sel == '0) ? NCH'(1) : ctl_sel;
   assign sw_go     = ctl_pwr && !busy && !ctl_burst &&
                      (ctl_start == START_SINGLE) && (start_q != START_SINGLE);
   assign bu_go     = ctl_pwr && !busy && ctl_burst && (ctl_start == START_NONE);
   assign last_tick = busy && tick && (tick_cnt == CNTW'(CONV_CLKS - 1));
   assign wr_en     = last_tick && ctl_pwr;
   assign irq       = |done_flags;

   adc_tick_gen #(.DIVW(DIVW)) tick_i (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy),
      .div  (ctl_div),
      .tick (tick)
   );

   adc_chan_pick #(.NCH(NCH)) pick_i (
      .sel    (sel_eff),
      .last   (conv_ch),
      .restart(sw_go || !scan_live),
      .ch     (ch_next)
   );

   adc_result_bank #(.NCH(NCH), .DW(DW)) bank_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_ch      (conv_ch),
      .wr_data    (sample_in),
      .rd_strobe  (rd_strobe),
      .result_flat(result_flat),
      .done_flags (done_flags),
      .ovr_flags  (ovr_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q   <= START_NONE;
         busy      <= 1'b0;
         scan_live <= 1'b0;
         tick_cnt  <= '0;
         conv_ch   <= '0;
      end else begin
         start_q <= ctl_start;
         if (!ctl_pwr) begin
            busy      <= 1'b0;
            scan_live <= 1'b0;
         end else if (!busy) begin
            if (sw_go || bu_go) begin
               busy      <= 1'b1;
               conv_ch   <= ch_next;
               tick_cnt  <= '0;
               scan_live <= bu_go;
            end else if (!ctl_burst) begin
               scan_live <= 1'b0;
            end
         end else if (tick) begin
            if (last_tick) busy <= 1'b0;
            else           tick_cnt <= tick_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
   parameter int NCH = 8,
   localparam int CHW = $clog2(NCH)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           ctl_pwr,
   input logic           ctl_burst,
   input logic [2:0]     ctl_start,
   input logic [NCH-1:0] rd_strobe,
   input logic [NCH-1:0] done_flags,
   input logic [NCH-1:0] ovr_flags,
   input logic           irq,
   input logic           busy,
   input logic [CHW-1:0] conv_ch
);
   // R8
   pwr_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_pwr |=> !busy);

   // R6
   burst_start_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && ctl_burst && ctl_start != 3'd0) |=> !busy);

   // R9
   finish_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && $past(ctl_pwr)) |-> done_flags[conv_ch]);

   // R10
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe != '0 && !busy) |=> ((done_flags & $past(rd_strobe)) == '0));

   // R11
   ovr_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flags & ~done_flags) == '0);

   // R12
   irq_fall_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> ($past(rd_strobe) != '0));
endmodule

bind adc_scan_seq adc_scan_chk #(.NCH(NCH)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctl_pwr   (ctl_pwr),
   .ctl_burst (ctl_burst),
   .ctl_start (ctl_start),
   .rd_strobe (rd_strobe),
   .done_flags(done_flags),
   .ovr_flags (ovr_flags),
   .irq       (irq),
   .busy      (busy),
   .conv_ch   (conv_ch)
);

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 8;
   localparam int DW  = 12;
   localparam int CONV = 65;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [7:0]      ctl_sel = 8'h01;
   logic [7:0]      ctl_div = 8'h00;
   logic            ctl_burst = 1'b0;
   logic [2:0]      ctl_start = 3'b000;
   logic            ctl_pwr = 1'b1;
   logic [DW-1:0]   sample_in = '0;
   logic [NCH-1:0]  rd_strobe = '0;
   logic [NCH*DW-1:0] result_flat;
   logic [NCH-1:0]  done_flags;
   logic [NCH-1:0]  ovr_flags;
   logic            irq;
   logic            busy;
   logic [2:0]      conv_ch;

   int checks = 0;
   int errors = 0;
   bit ended  = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   adc_scan_seq #(.NCH(NCH), .DW(DW), .DIVW(8), .CONV_CLKS(CONV)) dut_i (
      .clk(clk), .rst_n(rst_n), .ctl_sel(ctl_sel), .ctl_div(ctl_div),
      .ctl_burst(ctl_burst), .ctl_start(ctl_start), .ctl_pwr(ctl_pwr),
      .sample_in(sample_in), .rd_strobe(rd_strobe), .result_flat(result_flat),
      .done_flags(done_flags), .ovr_flags(ovr_flags), .irq(irq), .busy(busy),
      .conv_ch(conv_ch)
   );

   function automatic int low_ch(input logic [7:0] sel);
      if (sel == 0) return 0;
      for (int i = 0; i < 8; i++) if (sel[i]) return i;
      return 0;
   endfunction

   function automatic int next_ch(input logic [7:0] sel, input int last);
      for (int k = 1; k <= 8; k++) if (sel[(last + k) % 8]) return (last + k) % 8;
      return 0;
   endfunction

   function automatic int conv_len(input logic [7:0] div);
      return CONV * (int'(div) + 1);
   endfunction

   function automatic logic [DW-1:0] res_of(input int ch);
      return result_flat[ch*DW +: DW];
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic read_all();
      @(negedge clk) rd_strobe = '1;
      @(negedge clk) rd_strobe = '0;
   endtask

   // Drive a start code; count bus cycles busy stays high.
   task automatic sw_conv(input logic [7:0] sel, input logic [7:0] div,
                          input logic [DW-1:0] smp, input logic [2:0] code,
                          output int cyc);
      @(negedge clk);
      ctl_sel = sel; ctl_div = div; sample_in = smp; ctl_burst = 1'b0; ctl_start = code;
      @(posedge clk);
      cyc = 0;
      for (int n = 0; n < 70000; n++) begin
         @(negedge clk);
         if (!busy) break;
         cyc++;
      end
      ctl_start = 3'b000;
   endtask

   initial begin
      int cyc, ch, g, last;
      logic [7:0] sel, div;
      logic [DW-1:0] smp;
      void'($urandom(32'd4242));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done_flags == 0 && ovr_flags == 0 && !irq && !busy && result_flat == 0,
          "R12 reset state", int'(done_flags), 0);

      // R3 single conversion on ch5, divisor 0
      sw_conv(8'h20, 8'd0, 12'hABC, 3'b001, cyc);
      chk(cyc == conv_len(0), "R2 length div0", cyc, conv_len(0));
      chk(conv_ch == 5 && res_of(5) == 12'hABC, "R9 result ch5", int'(res_of(5)), 'hABC);
      chk(done_flags == 8'h20 && irq, "R12 done/irq after conversion", int'(done_flags), 'h20);

      // R11 overrun on second write without read
      sw_conv(8'h20, 8'd1, 12'h123, 3'b001, cyc);
      chk(cyc == conv_len(1), "R2 length div1", cyc, conv_len(1));
      chk(ovr_flags == 8'h20 && res_of(5) == 12'h123, "R11 overrun set", int'(ovr_flags), 'h20);

      // R10 read clears both flags, R12 irq drops
      read_all();
      chk(done_flags == 0 && ovr_flags == 0 && !irq, "R10 read clears", int'(done_flags), 0);

      // R1 zero select acts as ch0
      sw_conv(8'h00, 8'd0, 12'h777, 3'b001, cyc);
      chk(conv_ch == 0 && done_flags == 8'h01 && res_of(0) == 12'h777,
          "R1 zero select ch0", int'(done_flags), 1);
      read_all();

      // R3 multiple bits: lowest used
      sw_conv(8'b1011_0100, 8'd0, 12'h0F0, 3'b001, cyc);
      chk(conv_ch == 2 && done_flags == 8'h04, "R3 lowest selected", int'(conv_ch), 2);
      read_all();

      // R3 other code starts nothing
      sw_conv(8'h02, 8'd0, 12'h111, 3'b010, cyc);
      chk(cyc == 0 && done_flags == 0, "R3 code 010 ignored", cyc, 0);

      // R4/R6 burst with start code: nothing starts
      @(negedge clk) ctl_burst = 1'b1; ctl_sel = 8'h06;
      ctl_start = 3'b001;
      g = 0;
      repeat (200) begin
         @(negedge clk);
         if (busy) g++;
      end
      chk(g == 0 && done_flags == 0, "R4 R6 start during burst ignored", g, 0);
      ctl_burst = 1'b0; ctl_start = 3'b000;
      repeat (2) @(negedge clk);

      // R5 burst order and spacing
      sel = 8'b0101_0010; div = 8'd1;
      smp = 12'(($urandom() % 4096));
      sample_in = smp; ctl_sel = sel; ctl_div = div; ctl_burst = 1'b1;
      last = -1;
      for (int k = 0; k < 7; k++) begin
         g = 0;
         while (!busy) begin @(negedge clk); g++; end
         if (k > 0) chk(g == 1, "R5 one idle cycle between", g, 1);
         cyc = 1;
         for (int n = 0; n < 70000; n++) begin
            @(negedge clk);
            if (!busy) break;
            cyc++;
         end
         ch = (k == 0) ? low_ch(sel) : next_ch(sel, last);
         chk(cyc == conv_len(div), "R2 burst length", cyc, conv_len(div));
         chk(int'(conv_ch) == ch, "R5 burst order", int'(conv_ch), ch);
         chk(res_of(ch) == smp, "R9 burst result", int'(res_of(ch)), int'(smp));
         last = ch;
         smp = 12'(($urandom() % 4096));
         sample_in = smp;
      end

      // R7 clear burst mid conversion
      while (!busy) @(negedge clk);
      ch = int'(conv_ch);
      rd_strobe = '1;
      @(negedge clk) rd_strobe = '0;
      cyc = 2;
      repeat (30) begin @(negedge clk); cyc++; end
      ctl_burst = 1'b0;
      for (int n = 0; n < 70000; n++) begin
         @(negedge clk);
         if (!busy) break;
         cyc++;
      end
      chk(cyc == conv_len(div) && done_flags[ch], "R7 in-flight conversion finishes",
          cyc, conv_len(div));
      g = 0;
      repeat (2 * conv_len(div)) begin @(negedge clk); if (busy) g++; end
      chk(g == 0, "R7 no further conversions", g, 0);
      read_all();

      // R8 power drop mid conversion
      @(negedge clk) ctl_sel = 8'h08; ctl_div = 8'd0; ctl_start = 3'b001;
      repeat (20) @(negedge clk);
      ctl_pwr = 1'b0;
      @(negedge clk);
      chk(!busy, "R8 busy ends on power-down", int'(busy), 0);
      repeat (100) @(negedge clk);
      chk(done_flags == 0, "R8 no result after power-down", int'(done_flags), 0);
      ctl_start = 3'b000;
      @(negedge clk) ctl_start = 3'b001;
      g = 0;
      repeat (100) begin @(negedge clk); if (busy) g++; end
      chk(g == 0, "R8 start ignored while powered down", g, 0);
      ctl_start = 3'b000; ctl_pwr = 1'b1;
      repeat (2) @(negedge clk);

      // R10 write wins over simultaneous read
      sw_conv(8'h40, 8'd0, 12'h555, 3'b001, cyc);
      @(negedge clk) ctl_start = 3'b001;
      repeat (CONV) @(negedge clk);
      rd_strobe = 8'h40;
      @(negedge clk) rd_strobe = '0;
      chk(done_flags == 8'h40 && ovr_flags == 0 && !busy, "R10 write wins over read",
          int'(ovr_flags), 0);
      ctl_start = 3'b000;
      read_all();

      // Random single-channel conversions
      for (int k = 0; k < 6; k++) begin
         ch  = int'($urandom() % 8);
         div = 8'($urandom() % 4);
         smp = 12'($urandom() % 4096);
         sw_conv(8'(1 << ch), div, smp, 3'b001, cyc);
         chk(cyc == conv_len(div), "R2 random length", cyc, conv_len(div));
         chk(res_of(ch) == smp && done_flags == 8'(1 << ch), "R9 random result",
             int'(res_of(ch)), int'(smp));
         read_all();
      end

      if (!ended) begin
         ended = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule